// File: doc/BRIEF.md
# Branch Trace Record Stack

This block keeps a running history of the control-flow transfers that a processor core retires: taken branches, interrupts and exceptions. Each transfer is stored as a pair of addresses (where control came from, where it went) in a small circular stack. A top-of-stack pointer names the newest record, and the oldest record is overwritten once the stack is full. A separate pair of last-exception registers keeps the branch that was taken most recently before an interrupt or exception arrived.

A two-bit control register governs the block. One bit turns recording on. The other bit switches the single-step trap request so that it follows taken branches instead of every retired instruction. A debug exception clears the recording bit, so the history that led up to the debug event stays frozen until software sets the bit again. A branch and an interrupt or exception that retire in the same cycle are both written in that cycle, into consecutive slots, with the branch first. A combinational read port returns any stack entry by index, and the pointer, the control bits and the last-exception pair are visible as outputs.

When the depth is four, each entry is held as one 64-bit word: the from address sits in bits 63:32 and the to address in bits 31:0. Other depths keep separate from and to arrays.

Top module: `btr_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer, every stack entry, the last-exception pair and both control bits are cleared to zero.
- R2: A cycle with `ctl_wr_en` high loads `ctl_wr_data` into the control register on the next edge: bit 0 drives `ctl_rec_en` (recording on) and bit 1 drives `ctl_step_br` (single step on branches).
- R3: With `ctl_rec_en` high, a lone taken branch, or a lone interrupt or exception that is not a debug exception, writes its from/to pair into slot (tos+1) mod DEPTH, and `tos` becomes that slot on the next edge.
- R4: With `ctl_rec_en` low, transfers are ignored: `tos`, every entry and the last-exception pair keep their values.
- R5: With `ctl_rec_en` high, a branch together with a non-debug interrupt or exception in the same cycle writes the branch record into slot tos+1 and the event record into slot tos+2 (mod DEPTH), and `tos` advances by two.
- R6: The pointer wraps modulo DEPTH, and a new record overwrites the oldest one in place.
- R7: With `ctl_rec_en` high, any interrupt or exception (debug included) loads the last-exception pair with the newest branch record: the branch of the same cycle if there is one, otherwise the last branch written earlier (zero if none since reset). The event's own record never enters this pair.
- R8: A debug exception (`evt_valid` and `evt_debug` high) writes no record of its own, and `ctl_rec_en` reads zero from the next edge on, even when a control write occurs in the same cycle; a branch in the same cycle is still recorded.
- R9: `step_trap` is combinational: `tf_flag` AND (`br_valid` when `ctl_step_br` is 1, `insn_retire` when it is 0).
- R10: `rd_from` and `rd_to` show, combinationally, the from and to addresses of stack entry `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 2 | Control value: bit 0 recording on, bit 1 step on branches |
| ctl_rec_en | output | 1 | Recording enabled |
| ctl_step_br | output | 1 | Single step on branches selected |
| tf_flag | input | 1 | Trap flag of the core |
| insn_retire | input | 1 | An instruction retires this cycle |
| step_trap | output | 1 | Single-step trap request |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_from | input | 32 | Branch source address |
| br_to | input | 32 | Branch target address |
| evt_valid | input | 1 | An interrupt or exception is taken this cycle |
| evt_debug | input | 1 | The event is a debug exception |
| evt_from | input | 32 | Address interrupted by the event |
| evt_to | input | 32 | Handler address of the event |
| rd_idx | input | clog2(DEPTH) | Stack entry to read |
| rd_from | output | 32 | From address of the selected entry |
| rd_to | output | 32 | To address of the selected entry |
| tos | output | clog2(DEPTH) | Slot of the newest record |
| ler_from | output | 32 | Last-exception from address |
| ler_to | output | 32 | Last-exception to address |

## Verification
The assertions take for granted that DEPTH is a power of two, so that the pointer wraps by plain binary overflow, and that every input holds a known value from the end of reset on. `evt_debug` is treated as a qualifier with meaning only alongside `evt_valid`. The stimulus drives every input in each cycle from a loop counter, so all combinations of branch, event, debug flag, trap flag, retire strobe and control value occur with known values. Inputs change only at the falling edge, well away from the edge at which the design samples them.

// File: rtl/btr_pkg.sv
package btr_pkg;

    localparam int ADDR_W = 32;
    localparam int CTL_W = 2;
    localparam int CTL_REC_BIT = 0;
    localparam int CTL_STEP_BIT = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] from_a;
        logic [ADDR_W-1:0] to_a;
    } btr_rec_t;

    localparam btr_rec_t REC_ZERO = '{from_a: '0, to_a: '0};

    function automatic int idx_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    function automatic btr_rec_t make_rec(input logic [ADDR_W-1:0] f,
                                          input logic [ADDR_W-1:0] t);
        btr_rec_t r;
        r.from_a = f;
        r.to_a = t;
        return r;
    endfunction

endpackage

// File: rtl/btr_ctl.sv
module btr_ctl
    import btr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             dbg_hit,
    input  logic             tf_flag,
    input  logic             insn_retire,
    input  logic             br_taken,
    output logic             rec_on,
    output logic             step_br,
    output logic             step_trap
);

    logic rec_q;
    logic step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q  <= 1'b0;
            step_q <= 1'b0;
        end else begin
            if (wr_en) begin
                rec_q  <= wr_data[CTL_REC_BIT];
                step_q <= wr_data[CTL_STEP_BIT];
            end
            if (dbg_hit) begin
                rec_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (step_q) begin
            step_trap = tf_flag & br_taken;
        end else begin
            step_trap = tf_flag & insn_retire;
        end
    end

    assign rec_on  = rec_q;
    assign step_br = step_q;

endmodule

// File: rtl/btr_order.sv
module btr_order
    import btr_pkg::*;
(
    input  logic     rec_on,
    input  logic     br_valid,
    input  btr_rec_t br_rec,
    input  logic     evt_valid,
    input  logic     evt_debug,
    input  btr_rec_t evt_rec,
    output logic     w0_valid,
    output btr_rec_t w0_rec,
    output logic     w1_valid,
    output btr_rec_t w1_rec,
    output logic [1:0] push_cnt
);

    logic push_br;
    logic push_evt;

    always_comb begin
        push_br  = rec_on & br_valid;
        push_evt = rec_on & evt_valid & ~evt_debug;

        w0_valid = push_br | push_evt;
        w0_rec   = push_br ? br_rec : evt_rec;
        w1_valid = push_br & push_evt;
        w1_rec   = evt_rec;

        push_cnt = {1'b0, push_br} + {1'b0, push_evt};
    end

endmodule

// File: rtl/btr_store.sv
module btr_store
    import btr_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int IW     = 2,
    parameter bit PACKED = 1'b1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          w0_valid,
    input  btr_rec_t      w0_rec,
    input  logic          w1_valid,
    input  btr_rec_t      w1_rec,
    input  logic [1:0]    push_cnt,
    input  logic [IW-1:0] rd_idx,
    output btr_rec_t      rd_rec,
    output logic [IW-1:0] tos
);

    localparam int WORD_W = 2 * ADDR_W;

    logic [IW-1:0] tos_q;
    logic [IW-1:0] slot0;
    logic [IW-1:0] slot1;

    assign slot0 = tos_q + IW'(1);
    assign slot1 = tos_q + IW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
        end else begin
            tos_q <= tos_q + IW'(push_cnt);
        end
    end

    assign tos = tos_q;

    generate
        if (PACKED) begin : g_packed
            logic [WORD_W-1:0] word_q [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        word_q[i] <= '0;
                    end
                end else begin
                    if (w0_valid) begin
                        word_q[slot0] <= {w0_rec.from_a, w0_rec.to_a};
                    end
                    if (w1_valid) begin
                        word_q[slot1] <= {w1_rec.from_a, w1_rec.to_a};
                    end
                end
            end

            always_comb begin
                rd_rec.from_a = word_q[rd_idx][WORD_W-1:ADDR_W];
                rd_rec.to_a   = word_q[rd_idx][ADDR_W-1:0];
            end
        end else begin : g_split
            logic [ADDR_W-1:0] from_q [DEPTH];
            logic [ADDR_W-1:0] to_q   [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        from_q[i] <= '0;
                        to_q[i]   <= '0;
                    end
                end else begin
                    if (w0_valid) begin
                        from_q[slot0] <= w0_rec.from_a;
                        to_q[slot0]   <= w0_rec.to_a;
                    end
                    if (w1_valid) begin
                        from_q[slot1] <= w1_rec.from_a;
                        to_q[slot1]   <= w1_rec.to_a;
                    end
                end
            end

            always_comb begin
                rd_rec.from_a = from_q[rd_idx];
                rd_rec.to_a   = to_q[rd_idx];
            end
        end
    endgenerate

endmodule

// File: rtl/btr_ler.sv
module btr_ler
    import btr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rec_on,
    input  logic     br_valid,
    input  btr_rec_t br_rec,
    input  logic     evt_valid,
    output btr_rec_t ler_rec
);

    btr_rec_t last_br_q;
    btr_rec_t ler_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_br_q <= REC_ZERO;
            ler_q     <= REC_ZERO;
        end else if (rec_on) begin
            if (br_valid) begin
                last_br_q <= br_rec;
            end
            if (evt_valid) begin
                ler_q <= br_valid ? br_rec : last_br_q;
            end
        end
    end

    assign ler_rec = ler_q;

endmodule

// File: rtl/btr_stack.sv
module btr_stack
    import btr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = idx_bits(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    output logic              ctl_rec_en,
    output logic              ctl_step_br,
    input  logic              tf_flag,
    input  logic              insn_retire,
    output logic              step_trap,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_from,
    input  logic [ADDR_W-1:0] br_to,
    input  logic              evt_valid,
    input  logic              evt_debug,
    input  logic [ADDR_W-1:0] evt_from,
    input  logic [ADDR_W-1:0] evt_to,
    input  logic [IW-1:0]     rd_idx,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to,
    output logic [IW-1:0]     tos,
    output logic [ADDR_W-1:0] ler_from,
    output logic [ADDR_W-1:0] ler_to
);

    localparam bit PACKED = (DEPTH == 4);

    btr_rec_t br_rec;
    btr_rec_t evt_rec;
    btr_rec_t w0_rec;
    btr_rec_t w1_rec;
    btr_rec_t rd_rec;
    btr_rec_t ler_rec;
    logic     w0_valid;
    logic     w1_valid;
    logic [1:0] push_cnt;
    logic     rec_on;
    logic     dbg_hit;

    assign br_rec  = make_rec(br_from, br_to);
    assign evt_rec = make_rec(evt_from, evt_to);
    assign dbg_hit = evt_valid & evt_debug;

    btr_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .dbg_hit     (dbg_hit),
        .tf_flag     (tf_flag),
        .insn_retire (insn_retire),
        .br_taken    (br_valid),
        .rec_on      (rec_on),
        .step_br     (ctl_step_br),
        .step_trap   (step_trap)
    );

    btr_order u_order (
        .rec_on    (rec_on),
        .br_valid  (br_valid),
        .br_rec    (br_rec),
        .evt_valid (evt_valid),
        .evt_debug (evt_debug),
        .evt_rec   (evt_rec),
        .w0_valid  (w0_valid),
        .w0_rec    (w0_rec),
        .w1_valid  (w1_valid),
        .w1_rec    (w1_rec),
        .push_cnt  (push_cnt)
    );

    btr_store #(
        .DEPTH  (DEPTH),
        .IW     (IW),
        .PACKED (PACKED)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .w0_valid (w0_valid),
        .w0_rec   (w0_rec),
        .w1_valid (w1_valid),
        .w1_rec   (w1_rec),
        .push_cnt (push_cnt),
        .rd_idx   (rd_idx),
        .rd_rec   (rd_rec),
        .tos      (tos)
    );

    btr_ler u_ler (
        .clk       (clk),
        .rst       (rst),
        .rec_on    (rec_on),
        .br_valid  (br_valid),
        .br_rec    (br_rec),
        .evt_valid (evt_valid),
        .ler_rec   (ler_rec)
    );

    assign ctl_rec_en = rec_on;
    assign rd_from    = rd_rec.from_a;
    assign rd_to      = rd_rec.to_a;
    assign ler_from   = ler_rec.from_a;
    assign ler_to     = ler_rec.to_a;

endmodule

// File: rtl/btr_stack_chk.sv
module btr_stack_chk
    import btr_pkg::*;
#(
    parameter int IW = 2
)(
    input logic              clk,
    input logic              rst,
    input logic              ctl_rec_en,
    input logic              ctl_step_br,
    input logic              tf_flag,
    input logic              insn_retire,
    input logic              step_trap,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_from,
    input logic [ADDR_W-1:0] br_to,
    input logic              evt_valid,
    input logic              evt_debug,
    input logic [IW-1:0]     tos,
    input logic [ADDR_W-1:0] ler_from,
    input logic [ADDR_W-1:0] ler_to
);

    logic [1:0]    exp_cnt;
    logic [IW-1:0] exp_tos_next;

    assign exp_cnt = {1'b0, ctl_rec_en & br_valid}
                   + {1'b0, ctl_rec_en & evt_valid & ~evt_debug};
    assign exp_tos_next = tos + IW'(exp_cnt);

    // R3, R5, R6: pointer moves by the number of records pushed, modulo depth
    a_r3_tos_advance: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tos == $past(exp_tos_next));

    // R4: nothing moves while recording is off
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctl_rec_en |=> $stable(tos));

    // R8: a debug exception turns recording off
    a_r8_debug_clears: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_debug |=> !ctl_rec_en);

    // R7: same-cycle branch lands in the last-exception pair
    a_r7_ler_same_cycle: assert property (@(posedge clk) disable iff (rst)
        ctl_rec_en && evt_valid && br_valid
        |=> ler_from == $past(br_from) && ler_to == $past(br_to));

    // R7: the pair changes only on a recorded event
    a_r7_ler_stable: assert property (@(posedge clk) disable iff (rst)
        !(ctl_rec_en && evt_valid) |=> $stable(ler_from) && $stable(ler_to));

    // R9: in branch mode no trap without a branch
    a_r9_step_branch_mode: assert property (@(posedge clk) disable iff (rst)
        ctl_step_br && !br_valid |-> !step_trap);

    // R9: in instruction mode every retired instruction traps when TF is set
    a_r9_step_insn_mode: assert property (@(posedge clk) disable iff (rst)
        !ctl_step_br && tf_flag && insn_retire |-> step_trap);

endmodule

bind btr_stack btr_stack_chk #(.IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_rec_en  (ctl_rec_en),
    .ctl_step_br (ctl_step_br),
    .tf_flag     (tf_flag),
    .insn_retire (insn_retire),
    .step_trap   (step_trap),
    .br_valid    (br_valid),
    .br_from     (br_from),
    .br_to       (br_to),
    .evt_valid   (evt_valid),
    .evt_debug   (evt_debug),
    .tos         (tos),
    .ler_from    (ler_from),
    .ler_to      (ler_to)
);

// File: tb/btr_stack_test.sv
`timescale 1ns/1ps
module btr_stack_test;

    localparam int DEPTH = 4;
    localparam int IW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr_en = 1'b0;
    logic [1:0]  ctl_wr_data = '0;
    logic        ctl_rec_en;
    logic        ctl_step_br;
    logic        tf_flag = 1'b0;
    logic        insn_retire = 1'b0;
    logic        step_trap;
    logic        br_valid = 1'b0;
    logic [31:0] br_from = '0;
    logic [31:0] br_to = '0;
    logic        evt_valid = 1'b0;
    logic        evt_debug = 1'b0;
    logic [31:0] evt_from = '0;
    logic [31:0] evt_to = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [31:0] rd_from;
    logic [31:0] rd_to;
    logic [IW-1:0] tos;
    logic [31:0] ler_from;
    logic [31:0] ler_to;

    int checks = 0;
    int errors = 0;

    // bench-side expectations
    logic [31:0] m_from [DEPTH];
    logic [31:0] m_to   [DEPTH];
    int          m_tos = 0;
    logic [31:0] m_lf = '0, m_lt = '0, m_bf = '0, m_bt = '0;
    logic        m_en = 1'b0, m_btf = 1'b0;

    always #2 clk = ~clk;

    btr_stack #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rec_en(ctl_rec_en), .ctl_step_br(ctl_step_br),
        .tf_flag(tf_flag), .insn_retire(insn_retire), .step_trap(step_trap),
        .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .evt_valid(evt_valid), .evt_debug(evt_debug),
        .evt_from(evt_from), .evt_to(evt_to),
        .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to),
        .tos(tos), .ler_from(ler_from), .ler_to(ler_to)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string tos_req, input string ctl_req);
        check(tos_req, "tos", 32'(tos), 32'(m_tos));
        check(ctl_req, "rec enable", 32'(ctl_rec_en), 32'(m_en));
        check("R2", "step on branch", 32'(ctl_step_br), 32'(m_btf));
        check("R7", "ler from", ler_from, m_lf);
        check("R7", "ler to", ler_to, m_lt);
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = IW'(i);
            #0.1;
            check("R10", "entry from", rd_from, m_from[i]);
            check("R10", "entry to", rd_to, m_to[i]);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] wd,
                        input logic bv, input logic ev, input logic dbg,
                        input logic tf, input logic ir, input int k);
        logic rec;
        logic pb, pe;
        int   old_tos;
        int   cnt;
        string treq;
        ctl_wr_en = wr;  ctl_wr_data = wd;
        br_valid = bv;   evt_valid = ev;  evt_debug = dbg;
        tf_flag = tf;    insn_retire = ir;
        br_from  = 32'h4000_0000 | (32'(k) << 4);
        br_to    = 32'h5000_0000 + 32'(k) * 12;
        evt_from = 32'h6000_0000 + 32'(k) * 20;
        evt_to   = 32'h7000_0000 ^ 32'(k);
        #0.1;
        check("R9", "step trap", 32'(step_trap),
              32'(tf & (m_btf ? bv : ir)));
        @(posedge clk);
        rec = m_en;
        pb = rec & bv;
        pe = rec & ev & ~dbg;
        old_tos = m_tos;
        if (rec & ev) begin
            m_lf = pb ? br_from : m_bf;
            m_lt = pb ? br_to : m_bt;
        end
        if (pb) begin
            m_bf = br_from; m_bt = br_to;
        end
        cnt = 0;
        if (pb) begin
            cnt++;
            m_from[(m_tos + cnt) % DEPTH] = br_from;
            m_to[(m_tos + cnt) % DEPTH]   = br_to;
        end
        if (pe) begin
            cnt++;
            m_from[(m_tos + cnt) % DEPTH] = evt_from;
            m_to[(m_tos + cnt) % DEPTH]   = evt_to;
        end
        m_tos = (m_tos + cnt) % DEPTH;
        if (wr) begin
            m_en = wd[0]; m_btf = wd[1];
        end
        if (ev & dbg) m_en = 1'b0;
        if (cnt == 0)                treq = "R4";
        else if (old_tos + cnt >= DEPTH) treq = "R6";
        else if (cnt == 2)           treq = "R5";
        else                         treq = "R3";
        @(negedge clk);
        check_state(treq, (ev & dbg) ? "R8" : "R2");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_from[i] = '0; m_to[i] = '0;
        end
        // R1: reset state, with stray inputs active
        ctl_wr_en = 1'b1; ctl_wr_data = 2'b11; br_valid = 1'b1;
        br_from = 32'hdead_beef; evt_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ctl_wr_en = 1'b0; br_valid = 1'b0; evt_valid = 1'b0;
        rst = 1'b0;
        check_state("R1", "R1");

        // R2: enable recording
        step(1, 2'b01, 0, 0, 0, 0, 0, 1);
        // R3, R6: lone branches around the ring twice
        for (int k = 2; k < 10; k++) step(0, 2'b00, 1, 0, 0, 0, 0, k);
        // R7: lone interrupt takes the previous branch
        step(0, 2'b00, 0, 1, 0, 0, 0, 10);
        // R5: branch followed by interrupt in one cycle
        step(0, 2'b00, 1, 1, 0, 0, 0, 11);
        step(0, 2'b00, 1, 1, 0, 0, 0, 12);
        // R8: debug exception with a branch and a control write
        step(1, 2'b11, 1, 1, 1, 1, 1, 13);
        // R4: disabled, everything ignored
        step(0, 2'b00, 1, 1, 0, 1, 0, 14);
        step(0, 2'b00, 0, 1, 0, 1, 1, 15);

        // near-exhaustive sweep over all input combinations
        for (int k = 0; k < 256; k++) begin
            step(1'b1, {k[5], (k % 7) != 3}, k[0], k[1], k[2], k[3], k[4],
                 k + 100);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule